// File: doc/BRIEF.md
# Chained DMA Descriptor Sequencer

This block sequences DMA transfers for a host-to-card bridge. Software programs one transfer descriptor through a small register bank: card address, 64-bit host address, byte length, 64-bit pointer to the next descriptor, and an attribute word. It then writes the start bit of the control register. The sequencer launches the transfer on a shared engine command port and waits for the engine to report done or error. The command port carries a start pulse, the direction, the addresses, the length and a byte-swap mode. The data movers themselves sit outside this block.

When the attribute chain flag of the finished descriptor is set, the block fetches the next descriptor from host memory. It issues a single 28-byte read request on a valid/ready request stream, pointed at the stored next-descriptor address. It then accepts seven 32-bit words on a valid/ready return stream. These words are written straight into the working registers, and the block launches the new transfer. Back-pressure rules: the request holds `fr_valid` and a stable `fr_addr` until the cycle `fr_ready` is high. A returned word is taken in any cycle where both `fw_valid` and `fw_ready` are high. The source may insert idle cycles between words.

An interrupt line goes high once the last descriptor of a chain completes, or at once on an engine error. It stays high until software writes the status register. An abort command returns the block to idle without an interrupt.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset the status reads 0 (idle), `irq`, `eng_start`, `fr_valid` and `fw_ready` are 0, and every register reads 0.
- R2: Byte offsets decode as follows: 0x00 control, 0x04 status, 0x08 card address, 0x0C host address low, 0x10 host address high, 0x14 length, 0x18 next pointer low, 0x1C next pointer high, 0x20 attribute. Only bits [1:0] of the attribute are kept. Control reads back the byte-swap mode in bits [3:2]. Any other offset reads 0.
- R3: A control write with bit 0 set while idle makes `eng_start` high for exactly the following cycle, and the status reads 1 (busy). The engine outputs present the registers: `eng_dir` = attribute bit 0 (0 card-to-host, 1 host-to-card), and `eng_swap` = control bits [3:2] of that write. The swap codes are 0 unchanged, 1 all four bytes reversed, 2 16-bit halves exchanged, 3 bytes swapped within each half. The engine outputs stay stable while the engine works.
- R4: An `eng_done` while waiting, with attribute bit 1 clear, makes the status read 3 (done) and raises `irq` on the next cycle.
- R5: An `eng_done` while waiting, with attribute bit 1 set, raises `fr_valid` on the next cycle, with `fr_addr` = {next high, next low} and `fr_bytes` = 28, held until `fr_ready`. No interrupt is raised.
- R6: After the request is accepted, `fw_ready` is high. The seven accepted words load, in order, card address, host low, host high, length, next low, next high and attribute. The cycle after the seventh word, `eng_start` pulses with the new values.
- R7: An `eng_err` while waiting (it has priority over `eng_done`) makes the status read 2 (error), raises `irq`, returns to idle and abandons the chain.
- R8: `irq` stays high until any write to offset 0x04. A new interrupt event in the same cycle wins over the clear.
- R9: A control write with bit 1 set while busy returns to idle with status 0 and no interrupt. It drops `fr_valid`/`fw_ready`.
- R10: While busy, software writes to offsets 0x08 to 0x20 and further start commands are ignored.
- R11: `eng_done` and `eng_err` outside the waiting state have no effect on status, `irq` or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | ADDR_W | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` |
| eng_start | output | 1 | One-cycle transfer launch |
| eng_dir | output | 1 | 0 card-to-host, 1 host-to-card |
| eng_card_addr | output | 32 | Card address of the transfer |
| eng_host_addr | output | 64 | Host address of the transfer |
| eng_len | output | 32 | Byte length |
| eng_swap | output | 2 | Byte-swap mode |
| eng_done | input | 1 | Engine finished pulse |
| eng_err | input | 1 | Engine error pulse |
| fr_valid | output | 1 | Descriptor fetch request valid |
| fr_ready | input | 1 | Fetch request accepted |
| fr_addr | output | 64 | Host address of the next descriptor |
| fr_bytes | output | 8 | Request size in bytes (28) |
| fw_valid | input | 1 | Returned descriptor word valid |
| fw_ready | output | 1 | Ready for a descriptor word |
| fw_data | input | 32 | Returned descriptor word |
| irq | output | 1 | Pending interrupt |

## Verification
The bench builds the block with `ADDR_W` = 7, one bit wider than the default. This widening puts offsets beyond the register bank, such as 0x40, within reach, so that the reads of 0 there can be checked. All other widths are fixed by the descriptor format. The sequences cover a single transfer and a two-link chain with a stalled request and a gap in the returned words. They also cover an engine error, an abort in both the waiting and fetch phases, and stray engine pulses while idle.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int DESC_WORDS = 7;
  localparam int REQ_BYTES  = DESC_WORDS * 4;
  // word indices (byte offset / 4); descriptor words sit at consecutive indices
  localparam int IDX_CTRL  = 0;
  localparam int IDX_STAT  = 1;
  localparam int IDX_CARD  = 2;
  localparam int IDX_HLO   = 3;
  localparam int IDX_HHI   = 4;
  localparam int IDX_LEN   = 5;
  localparam int IDX_NLO   = 6;
  localparam int IDX_NHI   = 7;
  localparam int IDX_ATTR  = 8;
  localparam int IDX_FIRST = IDX_CARD;
  localparam int IDX_LAST  = IDX_FIRST + DESC_WORDS - 1;

  typedef enum logic [2:0] {
    S_IDLE, S_LAUNCH, S_WAIT, S_FREQ, S_FDATA
  } seq_state_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0, ST_BUSY = 2'd1, ST_ERROR = 2'd2, ST_DONE = 2'd3
  } stat_t;

  typedef struct packed {
    logic [31:0] card;
    logic [31:0] hlo;
    logic [31:0] hhi;
    logic [31:0] len;
    logic [31:0] nlo;
    logic [31:0] nhi;
    logic [1:0]  attr;
  } desc_t;
endpackage

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int IDXW = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic              busy,
  input  stat_t             status,
  input  logic              load_en,
  input  logic [IDXW-1:0]   load_idx,
  input  logic [31:0]       load_data,
  output desc_t             desc,
  output logic [1:0]        swap_q,
  output logic              go,
  output logic              abort_req,
  output logic              irq_clr
);
  logic [IDXW-1:0] widx;
  logic [31:0]     dreg [IDX_FIRST:IDX_LAST];

  assign widx      = csr_addr[ADDR_W-1:2];
  assign go        = csr_we && (widx == IDXW'(IDX_CTRL)) && csr_wdata[0] && !busy;
  assign abort_req = csr_we && (widx == IDXW'(IDX_CTRL)) && csr_wdata[1] && busy;
  assign irq_clr   = csr_we && (widx == IDXW'(IDX_STAT));

  function automatic logic [31:0] keep_bits(input int k, input logic [31:0] v);
    return (k == IDX_ATTR) ? {30'b0, v[1:0]} : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = IDX_FIRST; k <= IDX_LAST; k++) dreg[k] <= '0;
      swap_q <= '0;
    end else begin
      for (int k = IDX_FIRST; k <= IDX_LAST; k++) begin
        if (load_en && load_idx == IDXW'(k))
          dreg[k] <= keep_bits(k, load_data);
        else if (csr_we && !busy && widx == IDXW'(k))
          dreg[k] <= keep_bits(k, csr_wdata);
      end
      if (go) swap_q <= csr_wdata[3:2];
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (widx == IDXW'(IDX_CTRL)) csr_rdata = {28'b0, swap_q, 2'b00};
    else if (widx == IDXW'(IDX_STAT)) csr_rdata = {30'b0, status};
    else
      for (int k = IDX_FIRST; k <= IDX_LAST; k++)
        if (widx == IDXW'(k)) csr_rdata = dreg[k];
  end

  assign desc.card = dreg[IDX_CARD];
  assign desc.hlo  = dreg[IDX_HLO];
  assign desc.hhi  = dreg[IDX_HHI];
  assign desc.len  = dreg[IDX_LEN];
  assign desc.nlo  = dreg[IDX_NLO];
  assign desc.nhi  = dreg[IDX_NHI];
  assign desc.attr = dreg[IDX_ATTR][1:0];

  // R10: software writes while busy leave the working descriptor untouched
  p_busy_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && busy && !load_en) |=> $stable(desc));
endmodule

// File: rtl/dma_desc_loader.sv
module dma_desc_loader
  import dma_chain_pkg::*;
#(
  parameter int IDXW = 4,
  localparam int CW = $clog2(DESC_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            fw_valid,
  input  logic [31:0]     fw_data,
  output logic            fw_ready,
  output logic            load_en,
  output logic [IDXW-1:0] load_idx,
  output logic [31:0]     load_data,
  output logic            load_last
);
  logic [CW-1:0] cnt;

  assign fw_ready  = active;
  assign load_en   = active && fw_valid;
  assign load_idx  = IDXW'(IDX_FIRST) + IDXW'(cnt);
  assign load_data = fw_data;
  assign load_last = load_en && (cnt == CW'(DESC_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!active || load_last) cnt <= '0;
    else if (load_en) cnt <= cnt + 1'b1;
  end

  // R6: word counter never passes the descriptor size
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DESC_WORDS - 1));
  // R6: after the seventh word the return stream is closed
  p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_last |=> !fw_ready);
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       abort_req,
  input  logic       irq_clr,
  input  logic       chain,
  input  logic       eng_done,
  input  logic       eng_err,
  input  logic       fr_ready,
  input  logic       load_last,
  output seq_state_t state,
  output logic       busy,
  output logic       eng_start,
  output logic       fr_valid,
  output logic       fetch_active,
  output stat_t      status,
  output logic       irq
);
  seq_state_t nxt;
  logic       wait_err, wait_fin;

  assign wait_err = (state == S_WAIT) && eng_err && !abort_req;
  assign wait_fin = (state == S_WAIT) && !eng_err && eng_done && !chain && !abort_req;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:   if (go) nxt = S_LAUNCH;
      S_LAUNCH: nxt = S_WAIT;
      S_WAIT:   if (eng_err) nxt = S_IDLE;
                else if (eng_done) nxt = chain ? S_FREQ : S_IDLE;
      S_FREQ:   if (fr_ready) nxt = S_FDATA;
      S_FDATA:  if (load_last) nxt = S_LAUNCH;
      default:  nxt = S_IDLE;
    endcase
    if (abort_req) nxt = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      status <= ST_IDLE;
      irq    <= 1'b0;
    end else begin
      state <= nxt;
      if (abort_req)     status <= ST_IDLE;
      else if (go)       status <= ST_BUSY;
      else if (wait_err) status <= ST_ERROR;
      else if (wait_fin) status <= ST_DONE;
      if (wait_err || wait_fin) irq <= 1'b1;
      else if (irq_clr)         irq <= 1'b0;
    end
  end

  assign busy         = (state != S_IDLE);
  assign eng_start    = (state == S_LAUNCH);
  assign fr_valid     = (state == S_FREQ);
  assign fetch_active = (state == S_FDATA);

  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  p_busy_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> status == ST_BUSY);
  p_fetch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && !fr_ready && !abort_req) |=> fr_valid);
  p_err_report_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_WAIT) && eng_err && !abort_req) |=> (status == ST_ERROR) && irq && !busy);
  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !busy && status == ST_IDLE);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> !busy && $stable(status));
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              eng_start,
  output logic              eng_dir,
  output logic [31:0]       eng_card_addr,
  output logic [63:0]       eng_host_addr,
  output logic [31:0]       eng_len,
  output logic [1:0]        eng_swap,
  input  logic              eng_done,
  input  logic              eng_err,
  output logic              fr_valid,
  input  logic              fr_ready,
  output logic [63:0]       fr_addr,
  output logic [7:0]        fr_bytes,
  input  logic              fw_valid,
  output logic              fw_ready,
  input  logic [31:0]       fw_data,
  output logic              irq
);
  localparam int IDXW = ADDR_W - 2;

  desc_t           desc;
  logic [1:0]      swap_q;
  logic            go, abort_req, irq_clr, busy, fetch_active;
  logic            load_en, load_last;
  logic [IDXW-1:0] load_idx;
  logic [31:0]     load_data;
  stat_t           status;
  seq_state_t      state;

  dma_csr_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk, .rst_n, .csr_we, .csr_addr, .csr_wdata, .csr_rdata,
    .busy, .status, .load_en, .load_idx, .load_data,
    .desc, .swap_q, .go, .abort_req, .irq_clr
  );

  dma_desc_loader #(.IDXW(IDXW)) u_loader (
    .clk, .rst_n, .active(fetch_active), .fw_valid, .fw_data, .fw_ready,
    .load_en, .load_idx, .load_data, .load_last
  );

  dma_chain_seq u_seq (
    .clk, .rst_n, .go, .abort_req, .irq_clr, .chain(desc.attr[1]),
    .eng_done, .eng_err, .fr_ready, .load_last,
    .state, .busy, .eng_start, .fr_valid, .fetch_active, .status, .irq
  );

  assign eng_dir       = desc.attr[0];
  assign eng_card_addr = desc.card;
  assign eng_host_addr = {desc.hhi, desc.hlo};
  assign eng_len       = desc.len;
  assign eng_swap      = swap_q;
  assign fr_addr       = {desc.nhi, desc.nlo};
  assign fr_bytes      = 8'(REQ_BYTES);

  // R3: command outputs hold while the engine works
  p_eng_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_WAIT) && $past(state == S_WAIT)) |->
      $stable(eng_len) && $stable(eng_host_addr) && $stable(eng_card_addr)
      && $stable(eng_swap) && $stable(eng_dir));
  // R5: request address stays put until accepted
  p_fr_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && !fr_ready) |=> $stable(fr_addr));
endmodule

// File: tb/dma_chain_ctrl_tb.sv
`timescale 1ns/1ps
module dma_chain_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;

  logic clk = 0, rst_n = 0;
  logic csr_we = 0;
  logic [AW-1:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic eng_start, eng_dir;
  logic [31:0] eng_card_addr, eng_len;
  logic [63:0] eng_host_addr;
  logic [1:0] eng_swap;
  logic eng_done = 0, eng_err = 0;
  logic fr_valid, fr_ready = 0;
  logic [63:0] fr_addr;
  logic [7:0] fr_bytes;
  logic fw_valid = 0, fw_ready;
  logic [31:0] fw_data = '0;
  logic irq;

  int checks = 0, failures = 0;
  bit started = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chain_ctrl #(.ADDR_W(AW)) u_dut (
    .clk, .rst_n, .csr_we, .csr_addr, .csr_wdata, .csr_rdata,
    .eng_start, .eng_dir, .eng_card_addr, .eng_host_addr, .eng_len, .eng_swap,
    .eng_done, .eng_err, .fr_valid, .fr_ready, .fr_addr, .fr_bytes,
    .fw_valid, .fw_ready, .fw_data, .irq
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phase: 0 idle, 1 launching, 2 engine running, 3 requesting, 4 receiving
  int phase = 0, got = 0, m_stat = 0;
  bit m_irq = 0;
  logic [1:0] m_swap = 0;
  logic [31:0] m_reg [0:8] = '{default: 32'h0};

  always @(posedge clk) begin
    int idx;
    bit wr_go, wr_ab, wr_clr, chain, ev_err, ev_fin;
    if (!rst_n) begin
      phase = 0; got = 0; m_stat = 0; m_irq = 0; m_swap = 0;
      foreach (m_reg[i]) m_reg[i] = 0;
    end else begin
      idx    = int'(csr_addr) / 4;
      wr_go  = csr_we && idx == 0 && csr_wdata[0] && phase == 0;
      wr_ab  = csr_we && idx == 0 && csr_wdata[1] && phase != 0;
      wr_clr = csr_we && idx == 1;
      chain  = m_reg[8][1];
      ev_err = phase == 2 && eng_err && !wr_ab;
      ev_fin = phase == 2 && !eng_err && eng_done && !chain && !wr_ab;
      if (wr_ab) m_stat = 0;
      else if (wr_go) m_stat = 1;
      else if (ev_err) m_stat = 2;
      else if (ev_fin) m_stat = 3;
      if (ev_err || ev_fin) m_irq = 1;
      else if (wr_clr) m_irq = 0;
      if (wr_go) m_swap = csr_wdata[3:2];
      if (csr_we && phase == 0 && idx >= 2 && idx <= 8)
        m_reg[idx] = (idx == 8) ? (csr_wdata & 32'h3) : csr_wdata;
      if (phase == 4 && fw_valid)
        m_reg[2 + got] = (got == 6) ? (fw_data & 32'h3) : fw_data;
      if (wr_ab) begin phase = 0; got = 0; end
      else case (phase)
        0: if (wr_go) phase = 1;
        1: phase = 2;
        2: if (eng_err) phase = 0; else if (eng_done) phase = chain ? 3 : 0;
        3: if (fr_ready) begin phase = 4; got = 0; end
        4: if (fw_valid) begin
             if (got == 6) begin phase = 1; got = 0; end else got++;
           end
        default: phase = 0;
      endcase
    end
  end

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    int idx = int'(a) / 4;
    if (idx == 0) return {28'b0, m_swap, 2'b00};
    if (idx == 1) return 32'(m_stat);
    if (idx >= 2 && idx <= 8) return m_reg[idx];
    return 32'h0;
  endfunction

  always @(negedge clk) if (started) begin
    chk(eng_start === (phase == 1), "R3 eng_start vs model", 64'(eng_start), 64'(phase == 1));
    chk(fr_valid === (phase == 3), "R5 fr_valid vs model", 64'(fr_valid), 64'(phase == 3));
    chk(fw_ready === (phase == 4), "R6 fw_ready vs model", 64'(fw_ready), 64'(phase == 4));
    chk(irq === m_irq, "R8 irq vs model", 64'(irq), 64'(m_irq));
    chk(csr_rdata === exp_read(csr_addr), "R2 read data vs model", 64'(csr_rdata), 64'(exp_read(csr_addr)));
    if (phase == 1) begin
      chk(eng_len === m_reg[5] && eng_card_addr === m_reg[2], "R6 launch len/card",
          {eng_len, eng_card_addr}, {m_reg[5], m_reg[2]});
      chk(eng_host_addr === {m_reg[4], m_reg[3]}, "R3 launch host address",
          eng_host_addr, {m_reg[4], m_reg[3]});
      chk(eng_dir === m_reg[8][0] && eng_swap === m_swap, "R3 launch dir/swap",
          {eng_dir, eng_swap}, {m_reg[8][0], m_swap});
    end
    if (phase == 3)
      chk(fr_addr === {m_reg[7], m_reg[6]} && fr_bytes == 8'd28, "R5 request addr/size",
          fr_addr, {m_reg[7], m_reg[6]});
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1 csr_we = 1; csr_addr = AW'(a); csr_wdata = d;
    @(posedge clk); #1 csr_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(posedge clk); #1 csr_addr = AW'(a);
    @(negedge clk); d = csr_rdata;
  endtask

  task automatic pulse_done();
    @(posedge clk); #1 eng_done = 1;
    @(posedge clk); #1 eng_done = 0;
  endtask

  task automatic pulse_err();
    @(posedge clk); #1 eng_err = 1;
    @(posedge clk); #1 eng_err = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] words [7];
    idle(2);
    #2 started = 1;
    rst_n = 1;
    idle(1);
    // R1 reset state
    rd(32'h04, d); chk(d == 0, "R1 status after reset", d, 0);
    rd(32'h14, d); chk(d == 0, "R1 length after reset", d, 0);
    chk(!irq && !eng_start && !fr_valid && !fw_ready, "R1 outputs after reset",
        {irq, eng_start, fr_valid, fw_ready}, 0);

    // R2 map and masking
    wr(32'h08, 32'h0000_1000); wr(32'h0C, 32'h2000_0000); wr(32'h10, 32'h1);
    wr(32'h14, 32'h100); wr(32'h20, 32'hFFFF_FFFF);
    rd(32'h20, d); chk(d == 32'h3, "R2 attribute keeps two bits", d, 3);
    rd(32'h40, d); chk(d == 0, "R2 unmapped offset reads zero", d, 0);
    wr(32'h20, 32'h0);

    // R3 start with swap mode 1
    wr(32'h00, 32'h5);
    chk(eng_start && eng_swap == 2'd1 && eng_host_addr == 64'h1_2000_0000,
        "R3 launch pulse", {eng_start, eng_swap, eng_host_addr[31:0]}, {1'b1, 2'd1, 32'h2000_0000});
    rd(32'h04, d); chk(d == 1, "R3 status busy", d, 1);
    rd(32'h00, d); chk(d == 32'h4, "R2 control reads swap mode", d, 4);
    // R10 writes while busy ignored
    wr(32'h14, 32'h55); wr(32'h00, 32'h9);
    rd(32'h14, d); chk(d == 32'h100, "R10 length write ignored while busy", d, 32'h100);
    chk(eng_swap == 2'd1, "R10 restart ignored while busy", eng_swap, 1);
    // R4 completion
    pulse_done();
    chk(irq == 1, "R4 irq on final done", irq, 1);
    rd(32'h04, d); chk(d == 3, "R4 status done", d, 3);
    idle(3); chk(irq == 1, "R8 irq stays pending", irq, 1);
    wr(32'h04, 32'h0); chk(irq == 0, "R8 irq cleared by status write", irq, 0);

    // R5/R6 chained transfer, swap mode 2
    wr(32'h18, 32'h0000_3000); wr(32'h1C, 32'h0); wr(32'h20, 32'h3);
    wr(32'h00, 32'h9);
    pulse_done();
    chk(fr_valid && fr_addr == 64'h3000 && !irq, "R5 fetch request raised",
        {fr_valid, irq, fr_addr[31:0]}, {1'b1, 1'b0, 32'h3000});
    idle(2); chk(fr_valid == 1, "R5 request held without ready", fr_valid, 1);
    #1 fr_ready = 1; @(posedge clk); #1 fr_ready = 0;
    words = '{32'hA0, 32'hB0, 32'h0, 32'h40, 32'h0, 32'h0, 32'h0};
    for (int i = 0; i < 7; i++) begin
      if (i == 3) begin fw_valid = 0; @(posedge clk); #1; end
      fw_valid = 1; fw_data = words[i];
      @(posedge clk); #1;
    end
    fw_valid = 0;
    chk(eng_start && eng_len == 32'h40 && eng_card_addr == 32'hA0 && eng_dir == 0,
        "R6 next descriptor launched", {eng_len, eng_card_addr}, {32'h40, 32'hA0});
    rd(32'h20, d); chk(d == 0, "R6 attribute loaded from host", d, 0);
    pulse_done();
    chk(irq == 1, "R4 irq at end of chain", irq, 1);
    wr(32'h04, 32'h0);

    // R7 error
    wr(32'h20, 32'h2); wr(32'h00, 32'h1);
    idle(1); pulse_err();
    rd(32'h04, d); chk(d == 2 && irq, "R7 error status and irq", {irq, d}, {1'b1, 32'd2});
    chk(!fr_valid, "R7 chain abandoned", fr_valid, 0);
    wr(32'h04, 32'h0);

    // R9 abort while running, R11 stray pulses
    wr(32'h00, 32'h1); idle(2);
    wr(32'h00, 32'h2);
    rd(32'h04, d); chk(d == 0, "R9 abort returns to idle", d, 0);
    pulse_done(); pulse_err();
    rd(32'h04, d);
    chk(d == 0 && !irq && !fr_valid, "R11 stray engine pulses ignored", {irq, fr_valid, d}, 0);
    // R9 abort during fetch
    wr(32'h00, 32'h1); idle(1); pulse_done();
    chk(fr_valid == 1, "R9 fetch pending before abort", fr_valid, 1);
    wr(32'h00, 32'h2);
    chk(!fr_valid && !fw_ready && !irq, "R9 abort drops fetch", {fr_valid, fw_ready, irq}, 0);
    idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule